// File: doc/BRIEF.md
# Overlay Block Enable Bank

This block is a small bank of memory-mapped registers that decides which of a set of overlay address blocks are active. Each block owns a configuration word: a base field, a size code and a live enable. A separate staging word holds one shadow enable per block. Software fills the staging word first. It then issues one start command, and all staged enables take effect on the same clock edge. A stop command turns every block off and leaves each block's base and size as they were. The live enables leave the bank as a vector for the address-match logic.

A control word carries three write-only command bits: start, stop and data-cache flush. It also carries a configured-status flag and a guarded control flag. A debug requester can set the configured-status flag, and the CPU can clear it. The guarded flag changes only when its key bit is written in the same access. Every register honours per-byte write strobes. Both requesters use one write port, and a qualifier input marks writes that come from the debug side.

Register map: blocks sit at word addresses 0 to NUM_BLK-1. The staging word is at NUM_BLK and the control word at NUM_BLK+1. Block word layout: bit 0 is the live enable, bits 3:1 are the size code, bits 23:4 are the base, and bits 31:24 read as 0. Staging word: bit i is the shadow enable of block i. Control word: bit 0 start, bit 1 stop, bit 2 flush, bit 8 configured-status, bit 24 guarded flag, bit 31 key.

Top module: `ovl_enable_bank`

## Requirements
- R1: While reset is high and after it is released, all live enables, all shadow enables, the configured-status flag, the guarded flag and the flush output are 0.
- R2: A write of 1 to control bit 0 (start), without stop, loads every live enable from its shadow bit on that clock edge. The result is visible on `blk_en` in the next cycle.
- R3: A start issued while the staging word is all zero leaves every block disabled.
- R4: A write of 1 to control bit 1 (stop) clears all live enables. The base and size fields of every block read back unchanged.
- R5: When start and stop are written in the same access, stop wins and all live enables become 0.
- R6: Control bits 0, 1, 2 and 31 always read back as 0.
- R7: A write of 1 to control bit 2 from either requester raises `flush_req` for exactly one cycle, in the cycle after the write edge.
- R8: A debug write of 1 to control bit 8 sets the configured-status flag, and a CPU write of 0 to bit 8 clears it. A debug write of 0 and a CPU write of 1 leave the flag unchanged.
- R9: The guarded flag (control bit 24) takes the written value only when bit 31 is written as 1 in the same access. Otherwise it holds.
- R10: Only the bytes whose strobe is set are written, in every register. A command bit in a byte whose strobe is clear has no effect.
- R11: A write to a block word sets or clears that block's live enable through bit 0. `blk_en` bit i always equals bit 0 of block word i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one access |
| wr_dbg | input | 1 | Marks the access as coming from the debug requester |
| addr | input | ADDR_W | Word address of the access |
| wdata | input | 32 | Write data |
| wbe | input | 4 | Per-byte write strobes |
| rdata | output | 32 | Combinational read data at `addr` |
| blk_en | output | NUM_BLK | Live enable per overlay block |
| flush_req | output | 1 | One-cycle data-cache flush request |
| cfg_done | output | 1 | Configured-status flag |
| ctl_flag | output | 1 | Guarded control flag |

## Verification
The hardest states to reach are the ones where one edge carries competing updates to the same enable. These are a direct block write followed by a start that must override it, a start and stop together, and command bits sent in a byte whose strobe is off. The directed tasks arm a block directly and then start with a staging pattern that disagrees with it. They then issue combined start and stop writes, and masked command writes. Each of these is checked both on `blk_en` and through readback of the block words.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;
    localparam int CFG_W  = 24;

    // control word bit positions
    localparam int B_START = 0;
    localparam int B_STOP  = 1;
    localparam int B_FLUSH = 2;
    localparam int B_CFGD  = 8;
    localparam int B_FLAG  = 24;
    localparam int B_KEY   = 31;

    typedef struct packed {
        logic [19:0] base;
        logic [2:0]  size;
        logic        en;
    } blk_word_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic flush;
        logic cfg_hit;
        logic cfg_val;
        logic flag_hit;
        logic flag_val;
    } ctl_cmd_t;

    function automatic logic [DATA_W-1:0] be_to_mask(input logic [BE_W-1:0] be);
        logic [DATA_W-1:0] m;
        for (int b = 0; b < BE_W; b++) m[b*8 +: 8] = {8{be[b]}};
        return m;
    endfunction

    function automatic ctl_cmd_t decode_ctl(input logic sel,
                                            input logic [DATA_W-1:0] d,
                                            input logic [DATA_W-1:0] m);
        ctl_cmd_t c;
        c.start    = sel & m[B_START] & d[B_START];
        c.stop     = sel & m[B_STOP]  & d[B_STOP];
        c.flush    = sel & m[B_FLUSH] & d[B_FLUSH];
        c.cfg_hit  = sel & m[B_CFGD];
        c.cfg_val  = d[B_CFGD];
        c.flag_hit = sel & m[B_KEY] & d[B_KEY] & m[B_FLAG];
        c.flag_val = d[B_FLAG];
        return c;
    endfunction

endpackage

// File: rtl/ovl_blk_reg.sv
module ovl_blk_reg
    import ovl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    input  logic [CFG_W-1:0] wmask,
    input  logic             start_all,
    input  logic             stop_all,
    input  logic             shadow_bit,
    output blk_word_t        q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            if (wr) q <= blk_word_t'((q & ~wmask) | (wdata & wmask));
            // global commands override a direct write; stop beats start
            if (stop_all)       q.en <= 1'b0;
            else if (start_all) q.en <= shadow_bit;
        end
    end
endmodule

// File: rtl/ovl_ctl_reg.sv
module ovl_ctl_reg
    import ovl_pkg::*;
#(
    parameter int NUM_BLK = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shd_wr,
    input  logic [NUM_BLK-1:0] shd_data,
    input  logic [NUM_BLK-1:0] shd_mask,
    input  ctl_cmd_t           cmd,
    input  logic               from_dbg,
    output logic [NUM_BLK-1:0] shadow_q,
    output logic               flush_req,
    output logic               cfg_done,
    output logic               ctl_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q  <= '0;
            flush_req <= 1'b0;
            cfg_done  <= 1'b0;
            ctl_flag  <= 1'b0;
        end else begin
            if (shd_wr) shadow_q <= (shadow_q & ~shd_mask) | (shd_data & shd_mask);
            flush_req <= cmd.flush;
            if (cmd.cfg_hit) begin
                if (from_dbg && cmd.cfg_val)        cfg_done <= 1'b1;
                else if (!from_dbg && !cmd.cfg_val) cfg_done <= 1'b0;
            end
            if (cmd.flag_hit) ctl_flag <= cmd.flag_val;
        end
    end
endmodule

// File: rtl/ovl_enable_bank.sv
module ovl_enable_bank
    import ovl_pkg::*;
#(
    parameter int NUM_BLK = 16,
    parameter int ADDR_W  = $clog2(NUM_BLK + 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_dbg,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    input  logic [3:0]         wbe,
    output logic [31:0]        rdata,
    output logic [NUM_BLK-1:0] blk_en,
    output logic               flush_req,
    output logic               cfg_done,
    output logic               ctl_flag
);
    localparam logic [ADDR_W-1:0] SHD_ADDR = ADDR_W'(NUM_BLK);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_BLK + 1);

    logic [DATA_W-1:0]  wmask;
    ctl_cmd_t           cmd;
    logic [NUM_BLK-1:0] shadow_q;
    blk_word_t          blk_q [NUM_BLK];
    logic               unused_wdata;

    assign wmask        = be_to_mask(wbe);
    assign cmd          = decode_ctl(wr_en && addr == CTL_ADDR, wdata, wmask);
    assign unused_wdata = ^wdata[30:25];

    for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
        ovl_blk_reg u_blk (
            .clk        (clk),
            .rst        (rst),
            .wr         (wr_en && addr == ADDR_W'(i)),
            .wdata      (wdata[CFG_W-1:0]),
            .wmask      (wmask[CFG_W-1:0]),
            .start_all  (cmd.start),
            .stop_all   (cmd.stop),
            .shadow_bit (shadow_q[i]),
            .q          (blk_q[i])
        );
        assign blk_en[i] = blk_q[i].en;
    end

    ovl_ctl_reg #(.NUM_BLK(NUM_BLK)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .shd_wr    (wr_en && addr == SHD_ADDR),
        .shd_data  (wdata[NUM_BLK-1:0]),
        .shd_mask  (wmask[NUM_BLK-1:0]),
        .cmd       (cmd),
        .from_dbg  (wr_dbg),
        .shadow_q  (shadow_q),
        .flush_req (flush_req),
        .cfg_done  (cfg_done),
        .ctl_flag  (ctl_flag)
    );

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_BLK; i++)
            if (addr == ADDR_W'(i)) rdata = {{(DATA_W-CFG_W){1'b0}}, blk_q[i]};
        if (addr == SHD_ADDR) rdata[NUM_BLK-1:0] = shadow_q;
        if (addr == CTL_ADDR) begin
            rdata[B_CFGD] = cfg_done;
            rdata[B_FLAG] = ctl_flag;
        end
    end
endmodule

// File: rtl/ovl_enable_bank_chk.sv
module ovl_enable_bank_chk #(
    parameter int NUM_BLK = 16,
    parameter int ADDR_W  = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic               wr_dbg,
    input logic [ADDR_W-1:0]  addr,
    input logic [31:0]        wdata,
    input logic [3:0]         wbe,
    input logic [31:0]        rdata,
    input logic [NUM_BLK-1:0] blk_en,
    input logic               flush_req,
    input logic               cfg_done,
    input logic               ctl_flag,
    input logic [NUM_BLK-1:0] shadow_q
);
    logic ctl_w, do_stop, do_start, do_flush, key_w;
    assign ctl_w    = wr_en && addr == ADDR_W'(NUM_BLK + 1);
    assign do_stop  = ctl_w && wbe[0] && wdata[1];
    assign do_start = ctl_w && wbe[0] && wdata[0];
    assign do_flush = ctl_w && wbe[0] && wdata[2];
    assign key_w    = ctl_w && wbe[3] && wdata[31];

    // R4 R5: stop empties every live enable
    a_r4_stop_clears: assert property (@(posedge clk) disable iff (rst)
        do_stop |=> blk_en == '0);

    // R2: start alone loads the staged pattern
    a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
        (do_start && !do_stop) |=> blk_en == $past(shadow_q));

    // R7: flush request only follows a flush write
    a_r7_flush_cause: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> $past(do_flush));

    // R9: guarded flag holds unless the key accompanies it
    a_r9_flag_guard: assert property (@(posedge clk) disable iff (rst)
        !key_w |=> $stable(ctl_flag));

    // R8: configured flag rises only on a debug write of 1
    a_r8_cfg_set: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_done) |-> $past(ctl_w && wr_dbg && wbe[1] && wdata[8]));

    // R6: command and key bits read as zero
    a_r6_wo_zero: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_W'(NUM_BLK + 1)) |-> (rdata[2:0] == 3'b000 && !rdata[31]));
endmodule

bind ovl_enable_bank ovl_enable_bank_chk #(.NUM_BLK(NUM_BLK), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_dbg(wr_dbg), .addr(addr),
    .wdata(wdata), .wbe(wbe), .rdata(rdata), .blk_en(blk_en),
    .flush_req(flush_req), .cfg_done(cfg_done), .ctl_flag(ctl_flag),
    .shadow_q(shadow_q)
);

// File: tb/test_ovl_enable_bank.sv
module test_ovl_enable_bank;
    localparam int NB = 16;
    localparam int AW = 5;
    localparam logic [AW-1:0] SHD = AW'(NB);
    localparam logic [AW-1:0] CTL = AW'(NB + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0, wr_dbg = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [3:0]    wbe = '0;
    logic [31:0]   rdata;
    logic [NB-1:0] blk_en;
    logic          flush_req, cfg_done, ctl_flag;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    ovl_enable_bank #(.NUM_BLK(NB), .ADDR_W(AW)) i_ovl_enable_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_dbg(wr_dbg), .addr(addr),
        .wdata(wdata), .wbe(wbe), .rdata(rdata), .blk_en(blk_en),
        .flush_req(flush_req), .cfg_done(cfg_done), .ctl_flag(ctl_flag)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // write lands on the posedge between two negedges; state is visible on return
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be, input logic dbg);
        @(negedge clk);
        wr_en = 1'b1; wr_dbg = dbg; addr = a; wdata = d; wbe = be;
        @(negedge clk);
        wr_en = 1'b0; wr_dbg = 1'b0; wbe = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1", "blk_en", 32'(blk_en), 0);
        check("R1", "cfg_done", 32'(cfg_done), 0);
        check("R1", "ctl_flag", 32'(ctl_flag), 0);
        check("R1", "flush_req", 32'(flush_req), 0);
        rd(SHD, d); check("R1", "shadow", d, 0);
    endtask

    task automatic t_direct;
        logic [31:0] d;
        wr(AW'(3), 32'h00ABCDEB, 4'hF, 1'b0);
        check("R11", "blk_en after direct", 32'(blk_en), 32'h0008);
        rd(AW'(3), d); check("R11", "block3 word", d, 32'h00ABCDEB);
    endtask

    task automatic t_start;
        logic [31:0] d;
        wr(SHD, 32'h0000A5C3, 4'hF, 1'b0);
        wr(CTL, 32'h1, 4'h1, 1'b0);
        check("R2", "blk_en after start", 32'(blk_en), 32'hA5C3);
        rd(AW'(3), d); check("R11", "block3 en follows start", d, 32'h00ABCDEA);
    endtask

    task automatic t_stop;
        logic [31:0] d;
        wr(AW'(3), 32'h00ABCDEB, 4'hF, 1'b0);
        wr(CTL, 32'h2, 4'h1, 1'b0);
        check("R4", "blk_en after stop", 32'(blk_en), 0);
        rd(AW'(3), d); check("R4", "block3 config kept", d, 32'h00ABCDEA);
    endtask

    task automatic t_start_zero;
        wr(CTL, 32'h1, 4'h1, 1'b0);
        wr(SHD, 32'h0, 4'hF, 1'b0);
        wr(CTL, 32'h1, 4'h1, 1'b0);
        check("R3", "blk_en after zero start", 32'(blk_en), 0);
    endtask

    task automatic t_both;
        wr(SHD, 32'h0000FFFF, 4'hF, 1'b0);
        wr(CTL, 32'h1, 4'h1, 1'b0);
        check("R2", "all armed", 32'(blk_en), 32'hFFFF);
        wr(CTL, 32'h3, 4'h1, 1'b0);
        check("R5", "stop beats start", 32'(blk_en), 0);
    endtask

    task automatic t_flush;
        wr(CTL, 32'h4, 4'h1, 1'b0);
        check("R7", "flush high (cpu)", 32'(flush_req), 1);
        @(negedge clk);
        check("R7", "flush one cycle", 32'(flush_req), 0);
        wr(CTL, 32'h4, 4'h1, 1'b1);
        check("R7", "flush high (dbg)", 32'(flush_req), 1);
        @(negedge clk);
        check("R7", "flush dropped", 32'(flush_req), 0);
    endtask

    task automatic t_cfg;
        logic [31:0] d;
        wr(CTL, 32'h100, 4'h2, 1'b0);
        check("R8", "cpu write 1 ignored", 32'(cfg_done), 0);
        wr(CTL, 32'h100, 4'h2, 1'b1);
        check("R8", "dbg sets", 32'(cfg_done), 1);
        rd(CTL, d); check("R8", "readback bit8", d & 32'h100, 32'h100);
        wr(CTL, 32'h0, 4'h2, 1'b1);
        check("R8", "dbg write 0 ignored", 32'(cfg_done), 1);
        wr(CTL, 32'h0, 4'h2, 1'b0);
        check("R8", "cpu clears", 32'(cfg_done), 0);
    endtask

    task automatic t_guard;
        wr(CTL, 32'h01000000, 4'h8, 1'b0);
        check("R9", "no key no change", 32'(ctl_flag), 0);
        wr(CTL, 32'h81000000, 4'h8, 1'b0);
        check("R9", "key sets", 32'(ctl_flag), 1);
        wr(CTL, 32'h00000000, 4'h8, 1'b0);
        check("R9", "no key holds", 32'(ctl_flag), 1);
        wr(CTL, 32'h80000000, 4'h8, 1'b0);
        check("R9", "key clears", 32'(ctl_flag), 0);
    endtask

    task automatic t_wo;
        logic [31:0] d;
        wr(CTL, 32'h81000007, 4'hF, 1'b0);
        rd(CTL, d);
        check("R6", "wo bits read 0", d & 32'h80000007, 0);
        check("R6", "flag visible", d & 32'h01000000, 32'h01000000);
    endtask

    task automatic t_bytes;
        logic [31:0] d;
        wr(AW'(5), 32'h00123457, 4'hF, 1'b0);
        wr(AW'(5), 32'hFFFFFFFF, 4'h2, 1'b0);
        rd(AW'(5), d); check("R10", "block byte1 only", d, 32'h0012FF57);
        wr(SHD, 32'h0000BEEF, 4'hF, 1'b0);
        wr(SHD, 32'h00001200, 4'h2, 1'b0);
        rd(SHD, d); check("R10", "shadow byte1 only", d, 32'h000012EF);
        wr(CTL, 32'h00000001, 4'h2, 1'b0);
        check("R10", "masked start ignored", 32'(blk_en), 32'h0020);
    endtask

    initial begin
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_direct;
        t_start;
        t_stop;
        t_start_zero;
        t_both;
        t_flush;
        t_cfg;
        t_guard;
        t_wo;
        t_bytes;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule